// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Unit with Cascade and Status Outputs

This block combines two 4-bit operands under a 4-bit function select and a mode input. With the mode input low it runs one of sixteen arithmetic operations. These include add, one's-complement subtract, decrement, doubling and pass-through, and the carry-in is active-low. With the mode input high the internal carries are cut off and the block produces one of the sixteen Boolean functions of two variables, bit by bit.

For wider words, the block provides a ripple carry-out and active-low group generate and group propagate signals, which feed an external lookahead unit. It also provides an equality flag decoded from the result. In logic mode the cascade outputs are not left idle. The propagate output reports whether every result bit is one, the generate output is held inactive, and the carry-out repeats the propagate output gated by the carry-in. The XOR-type select therefore gives a cascadable bitwise equality check, and the NAND-type select gives an "any bit pair both high" check.

All outputs are registered once, with a synchronous active-high reset. Every output therefore reflects the inputs seen at the previous rising clock edge.

Top module: `alu4_status`

## Requirements
- R1: In a cycle after a clock edge with `rst` high, the outputs are `f`=0, `a_eq_b`=0, `grp_p_n`=1, `grp_g_n`=1 and `carry_out_n`=1.
- R2: Every output is a function of the `a`, `b`, `sel`, `logic_mode` and `carry_in_n` values sampled at the previous rising edge. A new input value changes no output before that edge.
- R3: With `logic_mode`=0, `f` is the low four bits of U+V+c, where c = NOT `carry_in_n`, and (U,V) by `sel` are: 0:(A,0) 1:(A|B,0) 2:(A|~B,0) 3:(15,0) 4:(A,A&~B) 5:(A|B,A&~B) 6:(A|~B,A&~B) 7:(15,A&~B) 8:(A,A&B) 9:(A|B,A&B) 10:(A|~B,A&B) 11:(15,A&B) 12:(A,A) 13:(A|B,A) 14:(A|~B,A) 15:(15,A).
- R4: With `logic_mode`=1, `f` by `sel` is: 0:~A 1:~(A|B) 2:~A&B 3:0 4:~(A&B) 5:~B 6:A^B 7:A&~B 8:~A|B 9:~(A^B) 10:B 11:A&B 12:all ones 13:A|~B 14:A|B 15:A.
- R5: With `logic_mode`=0, `carry_out_n` is 0 exactly when U+V+c from R3 is 16 or more.
- R6: With `logic_mode`=0, `grp_g_n` is 0 exactly when U+V is 16 or more, and `grp_p_n` is 0 exactly when every bit of U|V is 1. `carry_out_n` equals NOT(NOT `grp_g_n` OR (NOT `grp_p_n` AND NOT `carry_in_n`)).
- R7: `a_eq_b` is 1 exactly when all four bits of `f` are 1, in both modes.
- R8: With `sel`=6, `logic_mode`=0 and `carry_in_n`=1, `a_eq_b` is 1 exactly when A equals B, and `carry_out_n` is 1 exactly when A is less than or equal to B.
- R9: With `logic_mode`=1, `grp_g_n` is 1, `grp_p_n` is 0 exactly when all bits of `f` are 1, and `carry_out_n` equals `grp_p_n` AND `carry_in_n`.
- R10: With `sel`=9 and `logic_mode`=1, `grp_p_n` is 0 exactly when A equals B bit for bit.
- R11: With `sel`=4 and `logic_mode`=1, `grp_p_n` is 1 exactly when some bit position has both A and B at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| sel | input | 4 | Function select code |
| logic_mode | input | 1 | 1 selects Boolean functions, 0 selects arithmetic |
| carry_in_n | input | 1 | Ripple carry-in, active low |
| f | output | 4 | Registered result |
| a_eq_b | output | 1 | Registered all-ones flag on the result |
| grp_p_n | output | 1 | Group propagate, active low (status in logic mode) |
| grp_g_n | output | 1 | Group generate, active low (held 1 in logic mode) |
| carry_out_n | output | 1 | Ripple carry-out, active low (status in logic mode) |

## Verification
On every cycle the assertions check the following relations:
- the reset values;
- the link between the equality flag and the result;
- the logic-mode status outputs against the result and the carry-in;
- the arithmetic-mode carry-out against the group generate and group propagate outputs;
- the comparator meaning of the subtract code.

The arithmetic and Boolean function tables themselves, the exact group generate and group propagate values, and the one-cycle latency are shown only by the bench's scenarios. The bench sweeps every select code, mode and carry-in over all operand pairs against an independently written table, and it adds directed equality, any-pair-high and latency cases.

// File: rtl/alu4_status_pkg.sv
package alu4_status_pkg;

  // Function codes that carry a special meaning for status and comparison.
  typedef enum logic [3:0] {
    SEL_PASS      = 4'd0,
    SEL_NAND_ANY  = 4'd4,
    SEL_SUB       = 4'd6,
    SEL_ADD_XNOR  = 4'd9,
    SEL_DECR      = 4'd15
  } sel_code_e;

  localparam int unsigned SEL_W = 4;

  // Per-bit "wide" term: the bit set that always joins the sum.
  function automatic logic wide_term(input logic ai, input logic bi,
                                     input logic [SEL_W-1:0] s);
    return ai | (bi & s[0]) | (~bi & s[1]);
  endfunction

  // Per-bit "narrow" term: always a subset of the wide term.
  function automatic logic narrow_term(input logic ai, input logic bi,
                                       input logic [SEL_W-1:0] s);
    return (ai & bi & s[3]) | (ai & ~bi & s[2]);
  endfunction

endpackage

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms
  import alu4_status_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = wide_term(a[i], b[i], sel);
    assign gen[i]  = narrow_term(a[i], b[i], sel);
  end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             cin,
  output logic [WIDTH:0]   carry,
  output logic             grp_gen,
  output logic             grp_prop
);

  // Each carry is formed from its own prefix of generate/propagate terms,
  // so no carry waits on the previous bit's carry.
  assign carry[0] = cin;

  for (genvar k = 1; k <= WIDTH; k++) begin : g_carry
    logic pre_g;
    logic pre_p;
    always_comb begin
      pre_g = 1'b0;
      pre_p = 1'b1;
      for (int j = 0; j < k; j++) begin
        pre_g = gen[j] | (prop[j] & pre_g);
        pre_p = pre_p & prop[j];
      end
    end
    assign carry[k] = pre_g | (pre_p & cin);
  end

  always_comb begin
    grp_gen  = 1'b0;
    grp_prop = 1'b1;
    for (int j = 0; j < WIDTH; j++) begin
      grp_gen  = gen[j] | (prop[j] & grp_gen);
      grp_prop = grp_prop & prop[j];
    end
  end

endmodule

// File: rtl/alu4_result.sv
module alu4_result #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH:0]   carry,
  input  logic             grp_gen,
  input  logic             grp_prop,
  input  logic             logic_mode,
  input  logic             carry_in_n,
  output logic [WIDTH-1:0] f,
  output logic             all_ones,
  output logic             p_n,
  output logic             g_n,
  output logic             co_n
);

  logic [WIDTH-1:0] half;

  assign half = prop ^ gen;

  for (genvar i = 0; i < WIDTH; i++) begin : g_res
    assign f[i] = logic_mode ? ~half[i] : (half[i] ^ carry[i]);
  end

  assign all_ones = &f;

  always_comb begin
    if (logic_mode) begin
      p_n  = ~all_ones;
      g_n  = 1'b1;
      co_n = p_n & carry_in_n;
    end else begin
      p_n  = ~grp_prop;
      g_n  = ~grp_gen;
      co_n = ~carry[WIDTH];
    end
  end

endmodule

// File: rtl/alu4_status.sv
module alu4_status
  import alu4_status_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SEL_W-1:0] sel,
  input  logic             logic_mode,
  input  logic             carry_in_n,
  output logic [WIDTH-1:0] f,
  output logic             a_eq_b,
  output logic             grp_p_n,
  output logic             grp_g_n,
  output logic             carry_out_n
);

  logic [WIDTH-1:0] prop, gen, f_d;
  logic [WIDTH:0]   carry;
  logic             grp_gen, grp_prop, eq_d, p_d, g_d, co_d;

  alu4_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a(a), .b(b), .sel(sel), .prop(prop), .gen(gen)
  );

  alu4_lookahead #(.WIDTH(WIDTH)) u_cla (
    .prop(prop), .gen(gen), .cin(~carry_in_n), .carry(carry),
    .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  alu4_result #(.WIDTH(WIDTH)) u_res (
    .prop(prop), .gen(gen), .carry(carry), .grp_gen(grp_gen),
    .grp_prop(grp_prop), .logic_mode(logic_mode), .carry_in_n(carry_in_n),
    .f(f_d), .all_ones(eq_d), .p_n(p_d), .g_n(g_d), .co_n(co_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f           <= '0;
      a_eq_b      <= 1'b0;
      grp_p_n     <= 1'b1;
      grp_g_n     <= 1'b1;
      carry_out_n <= 1'b1;
    end else begin
      f           <= f_d;
      a_eq_b      <= eq_d;
      grp_p_n     <= p_d;
      grp_g_n     <= g_d;
      carry_out_n <= co_d;
    end
  end

endmodule

// File: rtl/alu4_status_chk.sv
module alu4_status_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       sel,
  input logic             logic_mode,
  input logic             carry_in_n,
  input logic [WIDTH-1:0] f,
  input logic             a_eq_b,
  input logic             grp_p_n,
  input logic             grp_g_n,
  input logic             carry_out_n
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (f == '0 && !a_eq_b && grp_p_n && grp_g_n && carry_out_n));

  // R7
  eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (a_eq_b == (&f)));

  // R9
  logic_g_idle_chk: assert property (@(posedge clk) disable iff (rst)
    logic_mode |=> grp_g_n);

  // R9
  logic_p_status_chk: assert property (@(posedge clk) disable iff (rst)
    logic_mode |=> (grp_p_n == !(&f)));

  // R9
  logic_cout_status_chk: assert property (@(posedge clk) disable iff (rst)
    logic_mode |=> (carry_out_n == (grp_p_n & $past(carry_in_n))));

  // R6
  arith_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    !logic_mode |=> (carry_out_n == !(!grp_g_n || (!grp_p_n && !$past(carry_in_n)))));

  // R8
  sub_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && sel == 4'd6 && carry_in_n) |=> (a_eq_b == ($past(a) == $past(b))));

  // R8
  sub_magnitude_chk: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && sel == 4'd6 && carry_in_n) |=> (carry_out_n == ($past(a) <= $past(b))));

endmodule

bind alu4_status alu4_status_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_alu4_status.sv
module test_alu4_status;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = '0, b = '0, sel = '0;
  logic       logic_mode = 1'b0, carry_in_n = 1'b1;
  logic [3:0] f;
  logic       a_eq_b, grp_p_n, grp_g_n, carry_out_n;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu4_status i_alu4_status (
    .clk(clk), .rst(rst), .a(a), .b(b), .sel(sel), .logic_mode(logic_mode),
    .carry_in_n(carry_in_n), .f(f), .a_eq_b(a_eq_b), .grp_p_n(grp_p_n),
    .grp_g_n(grp_g_n), .carry_out_n(carry_out_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Addend pair for arithmetic mode (R3 table).
  function automatic void addends(input logic [3:0] s, input logic [3:0] x,
                                  input logic [3:0] y, output logic [3:0] u,
                                  output logic [3:0] v);
    case (s[1:0])
      2'd0: u = x;
      2'd1: u = x | y;
      2'd2: u = x | ~y;
      default: u = 4'hF;
    endcase
    case (s[3:2])
      2'd0: v = 4'h0;
      2'd1: v = x & ~y;
      2'd2: v = x & y;
      default: v = x;
    endcase
  endfunction

  // Boolean result (R4 table).
  function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] x,
                                           input logic [3:0] y);
    case (s)
      4'd0:  return ~x;
      4'd1:  return ~(x | y);
      4'd2:  return ~x & y;
      4'd3:  return 4'h0;
      4'd4:  return ~(x & y);
      4'd5:  return ~y;
      4'd6:  return x ^ y;
      4'd7:  return x & ~y;
      4'd8:  return ~x | y;
      4'd9:  return ~(x ^ y);
      4'd10: return y;
      4'd11: return x & y;
      4'd12: return 4'hF;
      4'd13: return x | ~y;
      4'd14: return x | y;
      default: return x;
    endcase
  endfunction

  task automatic apply(input logic [3:0] x, input logic [3:0] y, input logic [3:0] s,
                       input logic m, input logic cn);
    @(negedge clk);
    a = x; b = y; sel = s; logic_mode = m; carry_in_n = cn;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(4'h5, 4'h3, 4'd9, 1'b0, 1'b0);
    apply(4'h5, 4'h3, 4'd9, 1'b0, 1'b0);
    check("R1 f", f, 0);
    check("R1 a_eq_b", a_eq_b, 0);
    check("R1 grp_p_n", grp_p_n, 1);
    check("R1 grp_g_n", grp_g_n, 1);
    check("R1 carry_out_n", carry_out_n, 1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int cn = 0; cn < 2; cn++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
              logic [3:0] u, v, fe;
              int sum;
              apply(4'(x), 4'(y), 4'(s), m[0], cn[0]);
              if (m == 0) begin
                addends(4'(s), 4'(x), 4'(y), u, v);
                sum = int'(u) + int'(v) + (cn == 0 ? 1 : 0);
                fe = 4'(sum);
                check("R3 arith f", f, fe);
                check("R5 carry_out_n", carry_out_n, (sum >= 16) ? 0 : 1);
                check("R6 grp_g_n", grp_g_n, ((int'(u) + int'(v)) >= 16) ? 0 : 1);
                check("R6 grp_p_n", grp_p_n, ((u | v) == 4'hF) ? 0 : 1);
              end else begin
                fe = logic_ref(4'(s), 4'(x), 4'(y));
                check("R4 logic f", f, fe);
                check("R9 grp_g_n", grp_g_n, 1);
                check("R9 grp_p_n", grp_p_n, (fe == 4'hF) ? 0 : 1);
                check("R9 carry_out_n", carry_out_n, (fe == 4'hF) ? 0 : cn);
              end
              check("R7 a_eq_b", a_eq_b, (fe == 4'hF) ? 1 : 0);
            end
  endtask

  task automatic t_compare();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(4'(x), 4'(y), 4'd6, 1'b0, 1'b1);
        check("R8 a_eq_b", a_eq_b, (x == y) ? 1 : 0);
        check("R8 carry_out_n", carry_out_n, (x <= y) ? 1 : 0);
      end
  endtask

  task automatic t_status();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(4'(x), 4'(y), 4'd9, 1'b1, 1'b1);
        check("R10 equality status", grp_p_n, (x == y) ? 0 : 1);
        apply(4'(x), 4'(y), 4'd4, 1'b1, 1'b0);
        check("R11 any-pair-high status", grp_p_n, ((x & y) != 0) ? 1 : 0);
      end
  endtask

  task automatic t_latency();
    apply(4'h3, 4'h4, 4'd9, 1'b0, 1'b1);
    check("R2 settled sum", f, 7);
    @(negedge clk);
    a = 4'h8; b = 4'h1;
    #1;
    check("R2 held before edge", f, 7);
    @(posedge clk);
    #1;
    check("R2 updated after one edge", f, 9);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_compare();
    t_status();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule